// File: doc/BRIEF.md
# Cache Replacement Victim Selector

This block keeps the replacement history of every set in an N-way set-associative cache and names the way that a miss should overwrite. The cache controller presents one lookup per cycle: the set index, an access strobe, whether the lookup hit, the way that hit, and the valid bits of the addressed set. The block answers in the same cycle with a victim way. It folds the lookup into its per-set history at the next clock edge. Tags, data arrays, the refill path and coherence stay outside.

A parameter fixes the policy at build time. The choices are exact LRU for two ways, binary-tree pseudo-LRU for four or eight ways, round-robin FIFO, FIFO that steps over the most recently touched way, and pseudo-random. In every mode an empty way is filled first. A miss writes the line into the named victim, and that fill counts as an access to the victim way.

The block has no sequencing state machine. Its only state is the per-set history array of the chosen policy, plus the random generator in random mode. All of this state is cleared by reset.

Top module: `repl_victim_sel`

## Requirements
- R1: After reset every set's history is cleared. With all four ways valid, the tree pseudo-LRU, FIFO and 2-way LRU selectors name way 0. The FIFO that skips the most recent way names way 1, because its cleared most-recent record also reads way 0.
- R2: When any bit of `valid_bits` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0, in every policy.
- R3: `victim_vld` is 1 exactly in cycles where `acc_valid` is 1 and `acc_hit` is 0.
- R4: In the tree, LRU and skip-MRU policies, a lookup that follows an access to the same set with all ways valid never names the way used by that access. The way used is `acc_way` on a hit and the victim on a miss.
- R5: The tree pseudo-LRU keeps one bit per internal node. An access sets each node on its path to point away from the accessed way. The victim follows the node bits from the root, where bit 0 means the lower half. With four ways, hits on ways 0,1,2,3 give victim 0, and a following hit on way 0 gives victim 2.
- R6: With two ways in LRU mode, the victim is always the way not used by the latest access to that set, whether that access was a hit or a fill.
- R7: In FIFO mode, each set's pointer advances by one, wrapping, on every miss to that set. Hits leave it unchanged, and the victim of a full set equals the pointer.
- R8: An access to one set leaves the victim of every other set unchanged.
- R9: In skip-MRU mode, the victim is the FIFO pointer, or the pointer plus one when the pointer equals the way most recently accessed in that set.
- R10: In random mode with all ways valid, the victim is taken from a free-running generator that steps every cycle. Over 16 consecutive cycles it names at least two different ways.
- R11: A miss that fills an empty way also updates the policy history as an access to that way. The tree is steered away from it, and the FIFO pointer still advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A lookup is presented this cycle |
| acc_set | input | log2(NUM_SETS) | Set index of the lookup |
| acc_hit | input | 1 | 1 when the lookup hit |
| acc_way | input | log2(NUM_WAYS) | Way that hit (ignored on a miss) |
| valid_bits | input | NUM_WAYS | Valid bit of each way of the addressed set |
| victim_way | output | log2(NUM_WAYS) | Way to overwrite for this set |
| victim_vld | output | 1 | A fill into `victim_way` happens this cycle |

## Verification
The empty-way priority and the policy history update fall in the same cycle when a miss arrives while one way of the set is still invalid. The priority encoder overrides the policy's choice, and the policy must still record the fill. The bench provokes this by first steering the tree with a hit, and then sending a miss with way 2 invalid; the FIFO selector gets the same miss. It judges the result by the victim the set names on the next lookup with all ways valid. That victim must be way 1 for both the tree and the FIFO, and differs from what either policy would give had the fill been skipped.

// File: rtl/repl_pkg.sv
package repl_pkg;

    typedef enum logic [2:0] {
        POL_LRU  = 3'd0,
        POL_PLRU = 3'd1,
        POL_FIFO = 3'd2,
        POL_NMRU = 3'd3,
        POL_RAND = 3'd4
    } repl_policy_e;

endpackage

// File: rtl/repl_plru_tree.sv
module repl_plru_tree #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int NODES = NUM_WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAY_W-1:0] upd_way,
    output logic [WAY_W-1:0] victim
);

    logic [NODES-1:0] tree_q [NUM_SETS];
    logic [NODES-1:0] cur_bits;
    logic [NODES-1:0] nxt_bits;

    assign cur_bits = tree_q[set_idx];

    // walk from the root following the stored node bits
    always_comb begin
        int node;
        node   = 0;
        victim = '0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            victim[WAY_W-1-lvl] = cur_bits[WAY_W'(node)];
            node = 2 * node + 1 + int'(cur_bits[WAY_W'(node)]);
        end
    end

    // point every node on the accessed path away from that way
    always_comb begin
        int node;
        node     = 0;
        nxt_bits = cur_bits;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            nxt_bits[WAY_W'(node)] = ~upd_way[WAY_W-1-lvl];
            node = 2 * node + 1 + int'(upd_way[WAY_W-1-lvl]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (upd_en) begin
            tree_q[set_idx] <= nxt_bits;
        end
    end

endmodule

// File: rtl/repl_fifo_ptr.sv
module repl_fifo_ptr #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter bit SKIP_MRU = 1'b1,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             fill_en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAY_W-1:0] used_way,
    output logic [WAY_W-1:0] victim
);

    logic [WAY_W-1:0] ptr_q [NUM_SETS];
    logic [WAY_W-1:0] ptr_cur;

    assign ptr_cur = ptr_q[set_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                ptr_q[s] <= '0;
            end
        end else if (fill_en) begin
            ptr_q[set_idx] <= ptr_cur + WAY_W'(1);
        end
    end

    generate
        if (SKIP_MRU) begin : g_skip
            logic [WAY_W-1:0] mru_q [NUM_SETS];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < NUM_SETS; s++) begin
                        mru_q[s] <= '0;
                    end
                end else if (acc_en) begin
                    mru_q[set_idx] <= used_way;
                end
            end

            assign victim = (ptr_cur == mru_q[set_idx]) ? ptr_cur + WAY_W'(1) : ptr_cur;
        end else begin : g_plain
            assign victim = ptr_cur;
        end
    endgenerate

endmodule

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
    parameter int            WIDTH = 16,
    parameter logic [15:0]   TAPS  = 16'hB400,
    parameter logic [15:0]   SEED  = 16'h0001
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= SEED[WIDTH-1:0];
        end else begin
            value <= {1'b0, value[WIDTH-1:1]} ^ (value[0] ? TAPS[WIDTH-1:0] : '0);
        end
    end

endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel
    import repl_pkg::*;
#(
    parameter int           NUM_SETS = 16,
    parameter int           NUM_WAYS = 4,
    parameter repl_policy_e POLICY   = POL_PLRU,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [SET_W-1:0]    acc_set,
    input  logic                acc_hit,
    input  logic [WAY_W-1:0]    acc_way,
    input  logic [NUM_WAYS-1:0] valid_bits,
    output logic [WAY_W-1:0]    victim_way,
    output logic                victim_vld
);

    logic [WAY_W-1:0] pol_victim;
    logic [WAY_W-1:0] empty_way;
    logic             empty_found;
    logic [WAY_W-1:0] used_way;
    logic             fill_now;

    // lowest-numbered empty way wins over the policy
    always_comb begin
        empty_found = 1'b0;
        empty_way   = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_bits[w]) begin
                empty_found = 1'b1;
                empty_way   = WAY_W'(w);
            end
        end
    end

    assign victim_way = empty_found ? empty_way : pol_victim;
    assign fill_now   = acc_valid & ~acc_hit;
    assign victim_vld = fill_now;
    assign used_way   = acc_hit ? acc_way : victim_way;

    generate
        if (POLICY == POL_LRU || POLICY == POL_PLRU) begin : g_tree
            repl_plru_tree #(
                .NUM_SETS (NUM_SETS),
                .NUM_WAYS (NUM_WAYS)
            ) u_tree (
                .clk     (clk),
                .rst_n   (rst_n),
                .upd_en  (acc_valid),
                .set_idx (acc_set),
                .upd_way (used_way),
                .victim  (pol_victim)
            );
        end else if (POLICY == POL_FIFO || POLICY == POL_NMRU) begin : g_fifo
            repl_fifo_ptr #(
                .NUM_SETS (NUM_SETS),
                .NUM_WAYS (NUM_WAYS),
                .SKIP_MRU (POLICY == POL_NMRU)
            ) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .acc_en   (acc_valid),
                .fill_en  (fill_now),
                .set_idx  (acc_set),
                .used_way (used_way),
                .victim   (pol_victim)
            );
        end else begin : g_rand
            logic [15:0] rnd;
            repl_lfsr #(
                .WIDTH (16)
            ) u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .value (rnd)
            );
            assign pol_victim = rnd[WAY_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/repl_victim_chk.sv
module repl_victim_chk
    import repl_pkg::*;
#(
    parameter int           NUM_SETS = 16,
    parameter int           NUM_WAYS = 4,
    parameter repl_policy_e POLICY   = POL_PLRU,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic [SET_W-1:0]    acc_set,
    input logic                acc_hit,
    input logic [WAY_W-1:0]    acc_way,
    input logic [NUM_WAYS-1:0] valid_bits,
    input logic [WAY_W-1:0]    victim_way,
    input logic                victim_vld
);

    logic                past_ok;
    logic [WAY_W-1:0]    used_w;
    logic [NUM_WAYS-1:0] below_mask;
    logic                all_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign used_w     = acc_hit ? acc_way : victim_way;
    assign below_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);
    assign all_valid  = &valid_bits;

    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !all_valid) |-> (!valid_bits[victim_way] && ((valid_bits & below_mask) == below_mask))); // R2

    AST_FILL_ONLY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> (acc_valid && !acc_hit)); // R3

    generate
        if (POLICY != POL_FIFO && POLICY != POL_RAND) begin : g_recency
            AST_NOT_LAST_USED: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(acc_valid) && acc_set == $past(acc_set) && all_valid)
                |-> (victim_way != $past(used_w))); // R4
        end
        if (POLICY == POL_FIFO) begin : g_fifo
            AST_FIFO_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(acc_valid && acc_hit) && acc_set == $past(acc_set)
                 && all_valid && $past(all_valid))
                |-> (victim_way == $past(victim_way))); // R7
            AST_FIFO_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(acc_valid && !acc_hit) && acc_set == $past(acc_set)
                 && all_valid && $past(all_valid))
                |-> (victim_way == $past(victim_way) + WAY_W'(1))); // R7
        end
    endgenerate

endmodule

bind repl_victim_sel repl_victim_chk #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .POLICY   (POLICY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_set    (acc_set),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .valid_bits (valid_bits),
    .victim_way (victim_way),
    .victim_vld (victim_vld)
);

// File: tb/repl_victim_sel_test.sv
module repl_victim_sel_test;
    import repl_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       avalid = 1'b0;
    logic [3:0] sset = '0;
    logic       hit = 1'b0;
    logic [1:0] way = '0;
    logic [3:0] vbits = 4'hF;

    logic [1:0] vw_plru, vw_fifo, vw_nmru, vw_rand;
    logic [0:0] vw_lru;
    logic       vld_plru, vld_lru, vld_fifo, vld_nmru, vld_rand;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    repl_victim_sel #(.NUM_SETS(16), .NUM_WAYS(4), .POLICY(POL_PLRU)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(avalid), .acc_set(sset), .acc_hit(hit),
        .acc_way(way), .valid_bits(vbits), .victim_way(vw_plru), .victim_vld(vld_plru));

    repl_victim_sel #(.NUM_SETS(16), .NUM_WAYS(2), .POLICY(POL_LRU)) uut_lru (
        .clk(clk), .rst_n(rst_n), .acc_valid(avalid), .acc_set(sset), .acc_hit(hit),
        .acc_way(way[0]), .valid_bits(vbits[1:0]), .victim_way(vw_lru), .victim_vld(vld_lru));

    repl_victim_sel #(.NUM_SETS(16), .NUM_WAYS(4), .POLICY(POL_FIFO)) uut_fifo (
        .clk(clk), .rst_n(rst_n), .acc_valid(avalid), .acc_set(sset), .acc_hit(hit),
        .acc_way(way), .valid_bits(vbits), .victim_way(vw_fifo), .victim_vld(vld_fifo));

    repl_victim_sel #(.NUM_SETS(16), .NUM_WAYS(4), .POLICY(POL_NMRU)) uut_nmru (
        .clk(clk), .rst_n(rst_n), .acc_valid(avalid), .acc_set(sset), .acc_hit(hit),
        .acc_way(way), .valid_bits(vbits), .victim_way(vw_nmru), .victim_vld(vld_nmru));

    repl_victim_sel #(.NUM_SETS(16), .NUM_WAYS(4), .POLICY(POL_RAND)) uut_rand (
        .clk(clk), .rst_n(rst_n), .acc_valid(avalid), .acc_set(sset), .acc_hit(hit),
        .acc_way(way), .valid_bits(vbits), .victim_way(vw_rand), .victim_vld(vld_rand));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs at the falling edge, settle, then let the caller sample
    task automatic step(input logic [3:0] s, input logic av, input logic h,
                        input logic [1:0] w, input logic [3:0] v);
        @(negedge clk);
        sset = s; avalid = av; hit = h; way = w; vbits = v;
        #1;
    endtask

    task automatic peek(input logic [3:0] s);
        step(s, 1'b0, 1'b0, 2'd0, 4'hF);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; avalid = 1'b0; hit = 1'b0; vbits = 4'hF;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        peek(4'd0);
        chk("R1 plru after reset", vw_plru, 0);
        chk("R1 lru after reset", vw_lru, 0);
        chk("R1 fifo after reset", vw_fifo, 0);
        chk("R1 nmru after reset", vw_nmru, 1);
        chk("R3 idle no fill", vld_plru, 0);
    endtask

    task automatic t_empty();
        do_reset();
        step(4'd1, 1'b0, 1'b0, 2'd0, 4'b1101);
        chk("R2 plru empty way", vw_plru, 1);
        chk("R2 fifo empty way", vw_fifo, 1);
        chk("R2 nmru empty way", vw_nmru, 1);
        chk("R2 rand empty way", vw_rand, 1);
        chk("R2 lru empty way", vw_lru, 1);
        step(4'd1, 1'b0, 1'b0, 2'd0, 4'b0110);
        chk("R2 lowest of two empty", vw_plru, 0);
    endtask

    task automatic t_vld();
        do_reset();
        step(4'd0, 1'b1, 1'b1, 2'd2, 4'hF);
        chk("R3 hit no fill", vld_plru, 0);
        step(4'd0, 1'b1, 1'b0, 2'd0, 4'hF);
        chk("R3 miss fills", vld_plru, 1);
    endtask

    task automatic t_plru();
        do_reset();
        for (int w = 0; w < 4; w++) begin
            step(4'd2, 1'b1, 1'b1, 2'(w), 4'hF);
            peek(4'd2);
            checks++;
            if (vw_plru == 2'(w)) begin
                errors++;
                $display("FAIL R4 victim equals last used actual=%0d expected!=%0d", vw_plru, w);
            end
        end
        chk("R5 after hits 0..3", vw_plru, 0);
        step(4'd2, 1'b1, 1'b1, 2'd0, 4'hF);
        peek(4'd2);
        chk("R5 after hit 0", vw_plru, 2);
    endtask

    task automatic t_lru();
        do_reset();
        step(4'd1, 1'b1, 1'b1, 2'd0, 4'hF);
        peek(4'd1);
        chk("R6 after hit 0", vw_lru, 1);
        step(4'd1, 1'b1, 1'b1, 2'd1, 4'hF);
        peek(4'd1);
        chk("R6 after hit 1", vw_lru, 0);
        step(4'd1, 1'b1, 1'b0, 2'd0, 4'hF);
        chk("R6 miss names lru", vw_lru, 0);
        peek(4'd1);
        chk("R6 after fill 0", vw_lru, 1);
    endtask

    task automatic t_fifo();
        do_reset();
        peek(4'd4);
        chk("R7 fifo start", vw_fifo, 0);
        step(4'd4, 1'b1, 1'b0, 2'd0, 4'hF);
        peek(4'd4);
        chk("R7 fifo after miss", vw_fifo, 1);
        step(4'd4, 1'b1, 1'b1, 2'd1, 4'hF);
        peek(4'd4);
        chk("R7 fifo hit holds", vw_fifo, 1);
        step(4'd4, 1'b1, 1'b0, 2'd0, 4'hF);
        step(4'd4, 1'b1, 1'b0, 2'd0, 4'hF);
        step(4'd4, 1'b1, 1'b0, 2'd0, 4'hF);
        peek(4'd4);
        chk("R7 fifo wraps", vw_fifo, 0);
    endtask

    task automatic t_sets();
        do_reset();
        step(4'd3, 1'b1, 1'b0, 2'd0, 4'hF);
        step(4'd3, 1'b1, 1'b1, 2'd0, 4'hF);
        peek(4'd5);
        chk("R8 fifo other set", vw_fifo, 0);
        chk("R8 plru other set", vw_plru, 0);
        peek(4'd3);
        chk("R8 fifo own set moved", vw_fifo, 1);
    endtask

    task automatic t_nmru();
        do_reset();
        step(4'd6, 1'b1, 1'b1, 2'd2, 4'hF);
        peek(4'd6);
        chk("R9 pointer not mru", vw_nmru, 0);
        step(4'd6, 1'b1, 1'b0, 2'd0, 4'hF);
        peek(4'd6);
        chk("R9 after fill way 0", vw_nmru, 1);
        step(4'd6, 1'b1, 1'b1, 2'd1, 4'hF);
        peek(4'd6);
        chk("R9 skip mru", vw_nmru, 2);
    endtask

    task automatic t_rand();
        logic [3:0] seen;
        do_reset();
        seen = '0;
        for (int i = 0; i < 16; i++) begin
            peek(4'd0);
            seen[vw_rand] = 1'b1;
        end
        chk("R10 random spread", ($countones(seen) >= 2) ? 1 : 0, 1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        step(4'd7, 1'b1, 1'b1, 2'd0, 4'hF);
        peek(4'd7);
        chk("R11 plru before fill", vw_plru, 2);
        step(4'd7, 1'b1, 1'b0, 2'd0, 4'b1011);
        chk("R11 plru fill empty way", vw_plru, 2);
        chk("R11 fifo fill empty way", vw_fifo, 2);
        peek(4'd7);
        chk("R11 plru records fill", vw_plru, 1);
        chk("R11 fifo advanced", vw_fifo, 1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_empty();
        t_vld();
        t_plru();
        t_lru();
        t_fifo();
        t_sets();
        t_nmru();
        t_rand();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule